// File: doc/BRIEF.md
# Conditional Data-Processing ALU with Flags

This block is the execute stage for the sixteen data-processing operations of a 32-bit load/store processor. It receives the instruction word, the first operand (the Rn value already read from the register file) and the second operand already produced by an external barrel shifter, together with that shifter's carry-out. It decides whether the instruction executes by testing the 4-bit condition field against the registered N/Z/C/V flags. When it executes, it produces the operation result and a write enable for the register file. It also computes the new flags.

The flags are held in a small register inside the block, with one bit each for N, Z, C and V. They change only on a clock edge where an instruction is issued, its condition passes, and the operation sets flags. Flags are set when the S bit is set, or always for the four compare-type operations. The next instruction issued sees the updated flags. The result path and the write enable are combinational from the inputs and the stored flags. The register file, the shifter and any special handling of a write to the program counter belong to the surrounding pipeline.

Top module: `cdp_alu`

## Requirements
- R1: After reset the flag output is 4'b0000, and with `exec_en` low `result_we` is 0. The flag output is packed as {N, Z, C, V}, with N at bit 3 and V at bit 0.
- R2: The condition is `instr[31:28]`. The codes are: 0 Z=1; 1 Z=0; 2 C=1; 3 C=0; 4 N=1; 5 N=0; 6 V=1; 7 V=0; 8 C=1 and Z=0; 9 C=0 or Z=1; 10 N=V; 11 N≠V; 12 Z=0 and N=V; 13 Z=1 or N≠V; 14 always; 15 never. A passing condition on a non-compare operation raises `result_we`.
- R3: A failing condition writes no result and leaves all four flags unchanged.
- R4: The opcode is `instr[24:21]`. The logical results are: 0 Rn AND op2; 1 Rn XOR op2; 12 Rn OR op2; 13 op2; 14 Rn AND NOT op2; 15 NOT op2.
- R5: A logical operation with S set (`instr[20]`=1) sets N to result bit 31 and Z to (result==0). It takes C from `shf_carry` and leaves V unchanged. The test operations 8 (AND) and 9 (XOR) follow the same rule.
- R6: Opcode 2 gives Rn−op2, opcode 3 gives op2−Rn, and opcode 4 gives Rn+op2. With S set, C is not-borrow for subtraction (1 when minuend ≥ subtrahend, unsigned) or carry-out for addition. V is signed overflow.
- R7: Opcode 5 gives Rn+op2+C. Opcode 6 gives Rn−op2−NOT C. Opcode 7 gives op2−Rn−NOT C. C and V follow R6, with C being the stored carry flag.
- R8: Opcodes 8–11 (AND-test, XOR-test, subtract-compare, add-compare) never raise `result_we`. They update the flags whenever their condition passes, whatever the S bit.
- R9: A non-compare operation with S clear writes its result and leaves the flags unchanged.
- R10: With `exec_en` low nothing is written and the flags hold.
- R11: An instruction issued in the cycle after a flag-setting instruction is tested against the flags that instruction produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | An instruction is issued this cycle |
| instr | input | 32 | Instruction word |
| rn_val | input | DW | First operand |
| shf_val | input | DW | Second operand from the shifter |
| shf_carry | input | 1 | Shifter carry-out |
| result | output | DW | Operation result |
| result_we | output | 1 | Write enable for the destination register |
| flags | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The assertions check the following on every cycle:
- A failing or never condition blocks the result write.
- Compare-type opcodes never write.
- The flags hold when no instruction is issued, when a condition fails, or when a non-compare operation has S clear.
- Logical operations preserve V.

The arithmetic values can only be shown by the bench's scenarios, which compare against a model built on wide signed and unsigned arithmetic. Those values are the carry and overflow of all six add/subtract forms at the 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF corners, the evaluation of all sixteen conditions against varied flags, and the back-to-back use of freshly written flags.

// File: rtl/cdpa_pkg.sv
package cdpa_pkg;

    localparam int unsigned IW = 32;

    // bit positions that the decode relies on
    localparam int unsigned COND_HI = 31;
    localparam int unsigned COND_LO = 28;
    localparam int unsigned OPC_HI  = 24;
    localparam int unsigned OPC_LO  = 21;
    localparam int unsigned SBIT    = 20;

    typedef enum logic [3:0] {
        OP_AND   = 4'h0,
        OP_XOR   = 4'h1,
        OP_SUB   = 4'h2,
        OP_RSUB  = 4'h3,
        OP_ADD   = 4'h4,
        OP_ADDC  = 4'h5,
        OP_SUBC  = 4'h6,
        OP_RSUBC = 4'h7,
        OP_TAND  = 4'h8,
        OP_TXOR  = 4'h9,
        OP_CSUB  = 4'hA,
        OP_CADD  = 4'hB,
        OP_OR    = 4'hC,
        OP_MOVE  = 4'hD,
        OP_CLR   = 4'hE,
        OP_NOT   = 4'hF
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_ZS     = 4'h0,
        CC_ZC     = 4'h1,
        CC_CS     = 4'h2,
        CC_CC     = 4'h3,
        CC_NS     = 4'h4,
        CC_NC     = 4'h5,
        CC_VS     = 4'h6,
        CC_VC     = 4'h7,
        CC_UGT    = 4'h8,
        CC_ULE    = 4'h9,
        CC_SGE    = 4'hA,
        CC_SLT    = 4'hB,
        CC_SGT    = 4'hC,
        CC_SLE    = 4'hD,
        CC_ALWAYS = 4'hE,
        CC_NEVER  = 4'hF
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/cdpa_cond_eval.sv
module cdpa_cond_eval
    import cdpa_pkg::*;
(
    input  cond_e cond,
    input  nzcv_t flg,
    output logic  pass
);

    always_comb begin
        pass = 1'b0;
        unique case (cond)
            CC_ZS:     pass = flg.z;
            CC_ZC:     pass = ~flg.z;
            CC_CS:     pass = flg.c;
            CC_CC:     pass = ~flg.c;
            CC_NS:     pass = flg.n;
            CC_NC:     pass = ~flg.n;
            CC_VS:     pass = flg.v;
            CC_VC:     pass = ~flg.v;
            CC_UGT:    pass = flg.c & ~flg.z;
            CC_ULE:    pass = ~flg.c | flg.z;
            CC_SGE:    pass = (flg.n == flg.v);
            CC_SLT:    pass = (flg.n != flg.v);
            CC_SGT:    pass = ~flg.z & (flg.n == flg.v);
            CC_SLE:    pass = flg.z | (flg.n != flg.v);
            CC_ALWAYS: pass = 1'b1;
            CC_NEVER:  pass = 1'b0;
        endcase
    end

    // R2: the never code cannot pass, the always code always passes
    always_comb begin
        if (cond == CC_NEVER)  a_r2_never_blocks:  assert (!pass);
        if (cond == CC_ALWAYS) a_r2_always_passes: assert (pass);
    end

endmodule

// File: rtl/cdpa_exec_unit.sv
module cdpa_exec_unit
    import cdpa_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  alu_op_e          op,
    input  logic [DW-1:0]    rn,
    input  logic [DW-1:0]    shf,
    input  logic             shf_c,
    input  nzcv_t            flg_in,
    output logic [DW-1:0]    res,
    output nzcv_t            flg_out,
    output logic             is_cmp
);

    localparam int unsigned MSB = DW - 1;

    logic [DW-1:0] add_x, add_y, logic_r;
    logic          add_ci, arith;
    logic [DW:0]   sum;
    logic          ovf;

    // operand steering: subtraction is done as x + ~y + carry-in
    always_comb begin
        add_x   = rn;
        add_y   = shf;
        add_ci  = 1'b0;
        logic_r = '0;
        arith   = 1'b0;
        is_cmp  = 1'b0;
        unique case (op)
            OP_AND:   logic_r = rn & shf;
            OP_XOR:   logic_r = rn ^ shf;
            OP_SUB:   begin arith = 1'b1; add_y = ~shf; add_ci = 1'b1; end
            OP_RSUB:  begin arith = 1'b1; add_x = shf; add_y = ~rn; add_ci = 1'b1; end
            OP_ADD:   arith = 1'b1;
            OP_ADDC:  begin arith = 1'b1; add_ci = flg_in.c; end
            OP_SUBC:  begin arith = 1'b1; add_y = ~shf; add_ci = flg_in.c; end
            OP_RSUBC: begin arith = 1'b1; add_x = shf; add_y = ~rn; add_ci = flg_in.c; end
            OP_TAND:  begin is_cmp = 1'b1; logic_r = rn & shf; end
            OP_TXOR:  begin is_cmp = 1'b1; logic_r = rn ^ shf; end
            OP_CSUB:  begin is_cmp = 1'b1; arith = 1'b1; add_y = ~shf; add_ci = 1'b1; end
            OP_CADD:  begin is_cmp = 1'b1; arith = 1'b1; end
            OP_OR:    logic_r = rn | shf;
            OP_MOVE:  logic_r = shf;
            OP_CLR:   logic_r = rn & ~shf;
            OP_NOT:   logic_r = ~shf;
        endcase
    end

    assign sum = {1'b0, add_x} + {1'b0, add_y} + {{DW{1'b0}}, add_ci};
    assign ovf = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);
    assign res = arith ? sum[MSB:0] : logic_r;

    always_comb begin
        flg_out.n = res[MSB];
        flg_out.z = (res == '0);
        flg_out.c = arith ? sum[DW] : shf_c;
        flg_out.v = arith ? ovf : flg_in.v;
    end

    // R5: the shifter carry passes through unchanged on logical operations
    always_comb begin
        if (!arith) a_r5_logic_carry_from_shifter: assert (flg_out.c == shf_c);
    end

endmodule

// File: rtl/cdpa_flag_store.sv
module cdpa_flag_store
    import cdpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  nzcv_t nxt,
    output nzcv_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= nxt;
    end

    // R10: without a write strobe the stored flags do not move
    a_r10_hold_without_write: assert property (
        @(posedge clk) disable iff (!rst_n) !we |=> $stable(q));

endmodule

// File: rtl/cdp_alu.sv
module cdp_alu
    import cdpa_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_en,
    input  logic [IW-1:0]   instr,
    input  logic [DW-1:0]   rn_val,
    input  logic [DW-1:0]   shf_val,
    input  logic            shf_carry,
    output logic [DW-1:0]   result,
    output logic            result_we,
    output logic [3:0]      flags
);

    cond_e   cond;
    alu_op_e op;
    logic    s_bit;
    logic    pass, is_cmp, flag_we;
    nzcv_t   flg_q, flg_nxt;
    logic    unused_instr_bits;

    assign cond  = cond_e'(instr[COND_HI:COND_LO]);
    assign op    = alu_op_e'(instr[OPC_HI:OPC_LO]);
    assign s_bit = instr[SBIT];
    assign unused_instr_bits = ^{instr[27:25], instr[19:0]};

    cdpa_cond_eval u_cond (
        .cond (cond),
        .flg  (flg_q),
        .pass (pass)
    );

    cdpa_exec_unit #(.DW(DW)) u_exec (
        .op      (op),
        .rn      (rn_val),
        .shf     (shf_val),
        .shf_c   (shf_carry),
        .flg_in  (flg_q),
        .res     (result),
        .flg_out (flg_nxt),
        .is_cmp  (is_cmp)
    );

    assign result_we = exec_en & pass & ~is_cmp;
    assign flag_we   = exec_en & pass & (s_bit | is_cmp);

    cdpa_flag_store u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .nxt   (flg_nxt),
        .q     (flg_q)
    );

    assign flags = flg_q;

    // R3: a failing condition writes nothing
    a_r3_fail_no_write: assert property (
        @(posedge clk) disable iff (!rst_n) (exec_en && !pass) |-> !result_we);

    // R3: a failing condition keeps the flags
    a_r3_fail_flags_hold: assert property (
        @(posedge clk) disable iff (!rst_n) (exec_en && !pass) |=> $stable(flags));

    // R2: the never code is never written
    a_r2_never_no_write: assert property (
        @(posedge clk) disable iff (!rst_n) (instr[31:28] == 4'hF) |-> !result_we);

    // R8: compare-type opcodes (10xx) never write a result
    a_r8_compare_no_write: assert property (
        @(posedge clk) disable iff (!rst_n) (instr[24:23] == 2'b10) |-> !result_we);

    // R5: logical operations keep V
    a_r5_logic_keeps_v: assert property (
        @(posedge clk) disable iff (!rst_n)
        (exec_en && ((instr[24:23] == 2'b11) || (instr[23:22] == 2'b00)))
        |=> (flags[0] == $past(flags[0])));

    // R9: S clear on a non-compare opcode leaves the flags alone
    a_r9_no_s_flags_hold: assert property (
        @(posedge clk) disable iff (!rst_n)
        (exec_en && !instr[20] && (instr[24:23] != 2'b10)) |=> $stable(flags));

    // R10: no issue, no write
    a_r10_idle_no_write: assert property (
        @(posedge clk) disable iff (!rst_n) !exec_en |-> !result_we);

endmodule

// File: tb/sim_cdp_alu.sv
module sim_cdp_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rn_val = '0;
    logic [31:0] shf_val = '0;
    logic        shf_carry = 1'b0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [3:0]  mflags = 4'h0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    cdp_alu #(.DW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .instr(instr),
        .rn_val(rn_val), .shf_val(shf_val), .shf_carry(shf_carry),
        .result(result), .result_we(result_we), .flags(flags)
    );

    typedef struct packed {
        logic        we;
        logic        fwe;
        logic        pass;
        logic [31:0] res;
        logic [3:0]  fl;
    } mres_t;

    function automatic logic cond_ok(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return c;
            4'h3: return !c;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return c && !z;
            4'h9: return !c || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // wide-arithmetic subtract: x - y - bw
    function automatic void wsub(input logic [31:0] x, y, input logic bw,
                                 output logic [31:0] r, output logic c, output logic v);
        longint du, ds;
        du = longint'({32'b0, x}) - longint'({32'b0, y}) - longint'(bw);
        ds = longint'($signed(x)) - longint'($signed(y)) - longint'(bw);
        r = du[31:0];
        c = (du >= 0);
        v = (ds > 64'sd2147483647) || (ds < -64'sd2147483648);
    endfunction

    function automatic void wadd(input logic [31:0] x, y, input logic ci,
                                 output logic [31:0] r, output logic c, output logic v);
        longint su, ss;
        su = longint'({32'b0, x}) + longint'({32'b0, y}) + longint'(ci);
        ss = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
        r = su[31:0];
        c = su[32];
        v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    endfunction

    function automatic mres_t model(input logic en, input logic [31:0] ins, a, b,
                                    input logic sc, input logic [3:0] f);
        mres_t m;
        logic [3:0] op;
        logic cmp, ar, c, v;
        logic [31:0] r;
        op  = ins[24:21];
        cmp = (op >= 4'h8) && (op <= 4'hB);
        ar  = 1'b1;
        c = 1'b0; v = 1'b0; r = '0;
        case (op)
            4'h0, 4'h8: begin ar = 0; r = a & b; end
            4'h1, 4'h9: begin ar = 0; r = a ^ b; end
            4'h2, 4'hA: wsub(a, b, 1'b0, r, c, v);
            4'h3:       wsub(b, a, 1'b0, r, c, v);
            4'h4, 4'hB: wadd(a, b, 1'b0, r, c, v);
            4'h5:       wadd(a, b, f[1], r, c, v);
            4'h6:       wsub(a, b, !f[1], r, c, v);
            4'h7:       wsub(b, a, !f[1], r, c, v);
            4'hC: begin ar = 0; r = a | b; end
            4'hD: begin ar = 0; r = b; end
            4'hE: begin ar = 0; r = a & ~b; end
            default: begin ar = 0; r = ~b; end
        endcase
        if (!ar) begin c = sc; v = f[0]; end
        m.pass = cond_ok(ins[31:28], f);
        m.we   = en && m.pass && !cmp;
        m.fwe  = en && m.pass && (ins[20] || cmp);
        m.res  = r;
        m.fl   = {r[31], (r == 0), c, v};
        return m;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string res_tag(input logic [3:0] op);
        if (op >= 4'h5 && op <= 4'h7) return "R7";
        if (op >= 4'h2 && op <= 4'h4) return "R6";
        return "R4";
    endfunction

    function automatic string flag_tag(input logic en, input logic [31:0] ins, input mres_t m);
        logic [3:0] op;
        op = ins[24:21];
        if (!en) return "R10";
        if (!m.pass) return "R3";
        if (op >= 4'h8 && op <= 4'hB) return "R8";
        if (!ins[20]) return "R9";
        if (op >= 4'h5 && op <= 4'h7) return "R7";
        if (op >= 4'h2 && op <= 4'h4) return "R6";
        return "R5";
    endfunction

    task automatic step(input logic en, input logic [31:0] ins, a, b,
                        input logic sc, input string tag);
        mres_t m;
        @(negedge clk);
        exec_en = en; instr = ins; rn_val = a; shf_val = b; shf_carry = sc;
        m = model(en, ins, a, b, sc, mflags);
        #1;
        chk((tag != "") ? tag : (!en ? "R10" : (m.pass ? "R2" : "R3")),
            {31'b0, result_we}, {31'b0, m.we});
        if (m.we) chk((tag != "") ? tag : res_tag(ins[24:21]), result, m.res);
        @(posedge clk);
        #1;
        if (m.fwe) mflags = m.fl;
        chk((tag != "") ? tag : flag_tag(en, ins, m), {28'b0, flags}, {28'b0, mflags});
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cc, input logic [3:0] op, input logic s);
        logic [31:0] w;
        w = $urandom;
        w[31:28] = cc; w[24:21] = op; w[20] = s;
        return w;
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom % 8)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            4: return 32'h1;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", {28'b0, flags}, 32'h0);
        chk("R1", {31'b0, result_we}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 corners
        step(1, mk(4'hE, 4'h2, 1), 32'd5, 32'd5, 0, "R6");          // Z=1 C=1
        step(1, mk(4'hE, 4'h2, 1), 32'd0, 32'd1, 0, "R6");          // N=1 C=0
        step(1, mk(4'hE, 4'h4, 1), 32'h7FFF_FFFF, 32'd1, 0, "R6");  // V=1
        step(1, mk(4'hE, 4'h4, 1), 32'hFFFF_FFFF, 32'd1, 0, "R6");  // C=1 Z=1
        step(1, mk(4'hE, 4'h3, 1), 32'd3, 32'd10, 0, "R6");         // 10-3
        // R7 carry-in forms, C now 1
        step(1, mk(4'hE, 4'h5, 1), 32'd1, 32'd1, 0, "R7");
        step(1, mk(4'hE, 4'h6, 1), 32'd9, 32'd4, 0, "R7");
        // R5 logical with shifter carry, V kept
        step(1, mk(4'hE, 4'hF, 1), 32'h0, 32'h0, 1, "R5");
        // R8 compare with S clear still sets flags
        step(1, mk(4'hE, 4'hA, 0), 32'd7, 32'd7, 0, "R8");
        // R11: EQ-conditioned move sees the flags just written
        step(1, mk(4'h0, 4'hD, 0), 32'd0, 32'hABCD, 0, "R11");
        step(1, mk(4'hE, 4'hA, 0), 32'd7, 32'd8, 0, "R11");
        step(1, mk(4'h0, 4'hD, 0), 32'd0, 32'h1234, 0, "R11");
        // R10: no issue
        step(0, mk(4'hE, 4'h4, 1), 32'hFFFF_FFFF, 32'd5, 1, "R10");
        // R9: S clear, result written, flags held
        step(1, mk(4'hE, 4'h2, 0), 32'd0, 32'd1, 0, "R9");
        // R3: never-condition
        step(1, mk(4'hF, 4'hB, 1), 32'd1, 32'd1, 0, "R3");

        for (int i = 0; i < 4000; i++) begin
            logic [3:0] cc;
            cc = ($urandom % 2) ? 4'hE : 4'($urandom);
            step(($urandom % 10) != 0, mk(cc, 4'($urandom), 1'($urandom)),
                 pick_val(), pick_val(), 1'($urandom), "");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule